// File: doc/BRIEF.md
# Raster-to-Block Mean Unit

This unit takes a stream of 8-bit gray pixels in raster order and produces one averaged value for every non-overlapping 4x4 tile of the frame. A one-cycle `frameStart` pulse marks the start of each frame. Each accepted pixel (`pixValid` high) moves the internal column and line position forward. The line length and the frame height are parameters, and line ends are found by counting pixels.

Incoming rows are gathered in groups of four into one half of a two-bank store. While the next four rows fill the other half, the completed band is read out tile by tile. Each tile's sixteen samples are summed in a 12-bit accumulator, and the sum is shifted right by four to give the mean. A registered output carries the mean together with the tile's band index, the tile's column index and the frame number, all qualified by a single-cycle strobe. A later stage can use this tag to look up per-tile history.

Top module: `blkmean_top`

## Requirements
- R1: While reset is held and after it is released, `blkValid` is low and `blkMean`, `blkRow`, `blkCol` and `blkFrame` are zero until the first tile is emitted.
- R2: `blkMean` equals the 12-bit sum of the tile's 16 pixels shifted right by 4, which is floor(sum/16). This covers the all-255 tile, whose mean is 255, and the all-0 tile, whose mean is 0.
- R3: The tile holding pixel (x, y) is tagged `blkCol` = x/4 and `blkRow` = y/4. Both always stay within FRAME_W/4 and FRAME_H/4.
- R4: Within one band, tiles leave in ascending column order. `blkCol` returns to 0 at the first tile of each band, and the row and frame tags stay constant across the band.
- R5: `blkValid` is a single-cycle pulse, issued exactly once per tile. Each frame yields (FRAME_W/4)*(FRAME_H/4) pulses.
- R6: `blkFrame` equals the number of `frameStart` pulses seen since reset, modulo 2^FRAME_NUM_W. It wraps at that width.
- R7: No tile of a band is emitted before the last pixel of that band's fourth row has been accepted. At full input rate (one pixel per cycle, no gaps), the readout of one band overlaps the writing of the next without corrupting either.
- R8: `pixData` is ignored in cycles where `pixValid` is low.
- R9: A tile carries the frame number that was current when its band was written, even if its readout continues after the next `frameStart`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frameStart | input | 1 | One-cycle pulse before the first pixel of a frame |
| pixValid | input | 1 | Qualifies `pixData` |
| pixData | input | PIX_W | Gray pixel value |
| blkValid | output | 1 | One-cycle strobe per tile |
| blkMean | output | PIX_W | Tile mean |
| blkRow | output | clog2(FRAME_H)-2 | Tile band index |
| blkCol | output | clog2(FRAME_W)-2 | Tile column index |
| blkFrame | output | FRAME_NUM_W | Frame number of the tile |

## Verification
The bound checker watches the tag sequence on every cycle. It checks that row and column indices stay in range, that columns step by one and restart at zero only after the last column, that row and frame tags hold across a band, and that the strobe never lasts two cycles. The correctness of the means, the frame count, and the absence of early or missing tiles can only be shown by the bench scenarios. These scenarios compare each emitted tile against means computed from the images the bench sent. They include saturated and zero images, random idle gaps with junk data, gapless full-rate frames, and frames started back-to-back so that the frame counter wraps.

// File: rtl/blkmean_pkg.sv
package blkmean_pkg;
  typedef struct packed {
    logic accumulate;  // a tile sample is being read this cycle
    logic loadFirst;   // first sample of a tile: restart the sum
    logic emit;        // last sample of a tile: register the result
  } ctrlStrobes_t;
endpackage

// File: rtl/blkmean_ctrl.sv
module blkmean_ctrl
  import blkmean_pkg::*;
#(
  parameter int FRAME_W     = 352,
  parameter int FRAME_H     = 288,
  parameter int FRAME_NUM_W = 8,
  localparam int DEPTH      = 8 * FRAME_W,
  localparam int ADDR_W     = $clog2(DEPTH),
  localparam int X_W        = $clog2(FRAME_W),
  localparam int Y_W        = $clog2(FRAME_H),
  localparam int BC_W       = X_W - 2,
  localparam int BR_W       = Y_W - 2,
  localparam int BLK_COLS   = FRAME_W / 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   frameStart,
  input  logic                   pixValid,
  output logic                   wrEn,
  output logic [ADDR_W-1:0]      wrAddr,
  output logic [ADDR_W-1:0]      rdAddr,
  output ctrlStrobes_t           strobes,
  output logic [BR_W-1:0]        tagRow,
  output logic [BC_W-1:0]        tagCol,
  output logic [FRAME_NUM_W-1:0] tagFrame
);
  logic [X_W-1:0]         wrX;
  logic [Y_W-1:0]         wrY;
  logic                   wrBank;
  logic [FRAME_NUM_W-1:0] frameCnt;
  logic                   rdBusy;
  logic                   rdBank;
  logic [3:0]             rdPix;
  logic [BC_W-1:0]        rdCol;
  logic [BR_W-1:0]        rdRow;
  logic [FRAME_NUM_W-1:0] rdFrame;

  logic pixAccept, lineEnd, bandDone, tileLast, rowLast;

  assign pixAccept = pixValid && !frameStart;
  assign lineEnd   = (wrX == X_W'(FRAME_W - 1));
  assign bandDone  = pixAccept && lineEnd && (wrY[1:0] == 2'b11);
  assign tileLast  = rdBusy && (rdPix == 4'hF);
  assign rowLast   = tileLast && (rdCol == BC_W'(BLK_COLS - 1));

  // write side: position in frame, bank toggle per four-row band
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wrX      <= '0;
      wrY      <= '0;
      wrBank   <= 1'b0;
      frameCnt <= '0;
    end else if (frameStart) begin
      wrX      <= '0;
      wrY      <= '0;
      frameCnt <= frameCnt + 1'b1;
    end else if (pixAccept) begin
      if (lineEnd) begin
        wrX <= '0;
        wrY <= (wrY == Y_W'(FRAME_H - 1)) ? '0 : wrY + 1'b1;
        if (wrY[1:0] == 2'b11) wrBank <= ~wrBank;
      end else begin
        wrX <= wrX + 1'b1;
      end
    end
  end

  // read side: one sample per cycle, sixteen per tile
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdBusy  <= 1'b0;
      rdBank  <= 1'b0;
      rdPix   <= '0;
      rdCol   <= '0;
      rdRow   <= '0;
      rdFrame <= '0;
    end else if (bandDone) begin
      rdBusy  <= 1'b1;
      rdBank  <= wrBank;
      rdPix   <= '0;
      rdCol   <= '0;
      rdRow   <= wrY[Y_W-1:2];
      rdFrame <= frameCnt;
    end else if (rdBusy) begin
      rdPix <= rdPix + 1'b1;
      if (rowLast)       rdBusy <= 1'b0;
      else if (tileLast) rdCol  <= rdCol + 1'b1;
    end
  end

  assign wrEn   = pixAccept;
  assign wrAddr = (wrBank ? ADDR_W'(4 * FRAME_W) : '0)
                + ADDR_W'(wrY[1:0]) * ADDR_W'(FRAME_W) + ADDR_W'(wrX);
  assign rdAddr = (rdBank ? ADDR_W'(4 * FRAME_W) : '0)
                + ADDR_W'(rdPix[3:2]) * ADDR_W'(FRAME_W)
                + ADDR_W'({rdCol, rdPix[1:0]});

  assign strobes.accumulate = rdBusy;
  assign strobes.loadFirst  = rdBusy && (rdPix == 4'h0);
  assign strobes.emit       = tileLast;
  assign tagRow   = rdRow;
  assign tagCol   = rdCol;
  assign tagFrame = rdFrame;
endmodule

// File: rtl/blkmean_dp.sv
module blkmean_dp
  import blkmean_pkg::*;
#(
  parameter int FRAME_W     = 352,
  parameter int FRAME_H     = 288,
  parameter int FRAME_NUM_W = 8,
  parameter int PIX_W       = 8,
  localparam int DEPTH      = 8 * FRAME_W,
  localparam int ADDR_W     = $clog2(DEPTH),
  localparam int BC_W       = $clog2(FRAME_W) - 2,
  localparam int BR_W       = $clog2(FRAME_H) - 2,
  localparam int SUM_W      = PIX_W + 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [PIX_W-1:0]       pixData,
  input  logic                   wrEn,
  input  logic [ADDR_W-1:0]      wrAddr,
  input  logic [ADDR_W-1:0]      rdAddr,
  input  ctrlStrobes_t           strobes,
  input  logic [BR_W-1:0]        tagRow,
  input  logic [BC_W-1:0]        tagCol,
  input  logic [FRAME_NUM_W-1:0] tagFrame,
  output logic                   blkValid,
  output logic [PIX_W-1:0]       blkMean,
  output logic [BR_W-1:0]        blkRow,
  output logic [BC_W-1:0]        blkCol,
  output logic [FRAME_NUM_W-1:0] blkFrame
);
  logic [PIX_W-1:0] bandMem [DEPTH];
  logic [SUM_W-1:0] acc;
  logic [SUM_W-1:0] sumNext;

  always_ff @(posedge clk) begin
    if (wrEn) bandMem[wrAddr] <= pixData;
  end

  assign sumNext = (strobes.loadFirst ? '0 : acc) + SUM_W'(bandMem[rdAddr]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc      <= '0;
      blkValid <= 1'b0;
      blkMean  <= '0;
      blkRow   <= '0;
      blkCol   <= '0;
      blkFrame <= '0;
    end else begin
      if (strobes.accumulate) acc <= sumNext;
      blkValid <= strobes.emit;
      if (strobes.emit) begin
        blkMean  <= sumNext[SUM_W-1:4];
        blkRow   <= tagRow;
        blkCol   <= tagCol;
        blkFrame <= tagFrame;
      end
    end
  end
endmodule

// File: rtl/blkmean_top.sv
module blkmean_top
  import blkmean_pkg::*;
#(
  parameter int FRAME_W     = 352,
  parameter int FRAME_H     = 288,
  parameter int FRAME_NUM_W = 8,
  parameter int PIX_W       = 8
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             frameStart,
  input  logic                             pixValid,
  input  logic [PIX_W-1:0]                 pixData,
  output logic                             blkValid,
  output logic [PIX_W-1:0]                 blkMean,
  output logic [$clog2(FRAME_H)-3:0]       blkRow,
  output logic [$clog2(FRAME_W)-3:0]       blkCol,
  output logic [FRAME_NUM_W-1:0]           blkFrame
);
  localparam int ADDR_W = $clog2(8 * FRAME_W);
  localparam int BC_W   = $clog2(FRAME_W) - 2;
  localparam int BR_W   = $clog2(FRAME_H) - 2;

  logic                   wrEn;
  logic [ADDR_W-1:0]      wrAddr;
  logic [ADDR_W-1:0]      rdAddr;
  ctrlStrobes_t           strobes;
  logic [BR_W-1:0]        tagRow;
  logic [BC_W-1:0]        tagCol;
  logic [FRAME_NUM_W-1:0] tagFrame;

  blkmean_ctrl #(
    .FRAME_W(FRAME_W), .FRAME_H(FRAME_H), .FRAME_NUM_W(FRAME_NUM_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .frameStart(frameStart), .pixValid(pixValid),
    .wrEn(wrEn), .wrAddr(wrAddr), .rdAddr(rdAddr), .strobes(strobes),
    .tagRow(tagRow), .tagCol(tagCol), .tagFrame(tagFrame)
  );

  blkmean_dp #(
    .FRAME_W(FRAME_W), .FRAME_H(FRAME_H), .FRAME_NUM_W(FRAME_NUM_W), .PIX_W(PIX_W)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .pixData(pixData), .wrEn(wrEn), .wrAddr(wrAddr),
    .rdAddr(rdAddr), .strobes(strobes), .tagRow(tagRow), .tagCol(tagCol),
    .tagFrame(tagFrame), .blkValid(blkValid), .blkMean(blkMean),
    .blkRow(blkRow), .blkCol(blkCol), .blkFrame(blkFrame)
  );
endmodule

// File: rtl/blkmean_chk.sv
module blkmean_chk #(
  parameter int FRAME_W     = 352,
  parameter int FRAME_H     = 288,
  parameter int FRAME_NUM_W = 8,
  parameter int PIX_W       = 8,
  localparam int BC_W       = $clog2(FRAME_W) - 2,
  localparam int BR_W       = $clog2(FRAME_H) - 2
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   blkValid,
  input logic [PIX_W-1:0]       blkMean,
  input logic [BR_W-1:0]        blkRow,
  input logic [BC_W-1:0]        blkCol,
  input logic [FRAME_NUM_W-1:0] blkFrame
);
  logic                   seen;
  logic [BC_W-1:0]        lastCol;
  logic [BR_W-1:0]        lastRow;
  logic [FRAME_NUM_W-1:0] lastFrame;
  logic [BC_W-1:0]        nextCol;

  assign nextCol = lastCol + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen      <= 1'b0;
      lastCol   <= '0;
      lastRow   <= '0;
      lastFrame <= '0;
    end else if (blkValid) begin
      seen      <= 1'b1;
      lastCol   <= blkCol;
      lastRow   <= blkRow;
      lastFrame <= blkFrame;
    end
  end

  assert_col_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    blkValid |-> (int'(blkCol) < FRAME_W / 4));

  assert_row_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    blkValid |-> (int'(blkRow) < FRAME_H / 4));

  assert_col_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (blkValid && seen && blkCol != '0) |->
      (blkCol == nextCol && blkRow == lastRow && blkFrame == lastFrame));

  assert_col_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (blkValid && seen && blkCol == '0) |-> (int'(lastCol) == FRAME_W / 4 - 1));

  assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    blkValid |=> !blkValid);

  assert_no_mean_change_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!blkValid && !$past(blkValid)) |-> $stable(blkMean));
endmodule

bind blkmean_top blkmean_chk #(
  .FRAME_W(FRAME_W), .FRAME_H(FRAME_H), .FRAME_NUM_W(FRAME_NUM_W), .PIX_W(PIX_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .blkValid(blkValid), .blkMean(blkMean),
  .blkRow(blkRow), .blkCol(blkCol), .blkFrame(blkFrame)
);

// File: tb/blkmean_top_tb.sv
module blkmean_top_tb;
  localparam int W  = 32;
  localparam int H  = 12;
  localparam int FN = 3;
  localparam int BC = W / 4;
  localparam int BR = H / 4;
  localparam int NFRAMES = 10;

  typedef struct packed {
    logic [7:0]    mean;
    logic [1:0]    row;
    logic [2:0]    col;
    logic [FN-1:0] frame;
  } tile_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frameStart = 1'b0;
  logic pixValid = 1'b0;
  logic [7:0] pixData = '0;
  logic blkValid;
  logic [7:0] blkMean;
  logic [1:0] blkRow;
  logic [2:0] blkCol;
  logic [FN-1:0] blkFrame;

  always #5 clk = ~clk;

  blkmean_top #(.FRAME_W(W), .FRAME_H(H), .FRAME_NUM_W(FN), .PIX_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .frameStart(frameStart), .pixValid(pixValid),
    .pixData(pixData), .blkValid(blkValid), .blkMean(blkMean),
    .blkRow(blkRow), .blkCol(blkCol), .blkFrame(blkFrame)
  );

  int checks = 0;
  int errors = 0;
  int validCount = 0;
  logic [7:0] img [H][W];
  tile_t expQ [$];
  logic [FN-1:0] expFrame = '0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] tileMean(input int by, input int bx);
    int s = 0;
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 4; c++) s += img[by*4+r][bx*4+c];
    return 8'(s / 16);
  endfunction

  task automatic fillImage(input int mode);
    for (int y = 0; y < H; y++)
      for (int x = 0; x < W; x++)
        case (mode)
          0: img[y][x] = 8'hFF;
          1: img[y][x] = 8'h00;
          2: img[y][x] = 8'((x * 7 + y * 13) & 8'hFF);
          default: img[y][x] = 8'($urandom_range(0, 255));
        endcase
  endtask

  task automatic sendFrame(input int gapPct);
    @(negedge clk);
    frameStart = 1'b1;
    pixValid   = 1'b0;
    expFrame   = expFrame + 1'b1;
    @(negedge clk);
    frameStart = 1'b0;
    for (int y = 0; y < H; y++) begin
      for (int x = 0; x < W; x++) begin
        while ($urandom_range(0, 99) < gapPct) begin
          pixValid = 1'b0;
          pixData  = 8'($urandom_range(0, 255));  // junk during idle, R8
          @(negedge clk);
        end
        pixValid = 1'b1;
        pixData  = img[y][x];
        if ((y % 4) == 3 && x == W - 1)
          for (int bx = 0; bx < BC; bx++)
            expQ.push_back('{tileMean(y / 4, bx), 2'(y / 4), 3'(bx), expFrame});
        if (!(y == H - 1 && x == W - 1)) @(negedge clk);
      end
    end
  endtask

  // output monitor
  always @(negedge clk) begin
    if (rst_n && blkValid) begin
      validCount++;
      if (expQ.size() == 0) begin
        check(1'b0, "R7 tile before band complete", 1, 0);
      end else begin
        tile_t e;
        e = expQ.pop_front();
        check(blkMean == e.mean, "R2 mean", blkMean, e.mean);
        check(blkRow == e.row && blkCol == e.col, "R3 tag", {blkRow, blkCol}, {e.row, e.col});
        check(blkFrame == e.frame, "R6 R9 frame tag", blkFrame, e.frame);
      end
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check(!blkValid && blkMean == 0 && blkRow == 0 && blkCol == 0 && blkFrame == 0,
          "R1 reset state", {blkValid, blkMean}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!blkValid && blkMean == 0, "R1 after release", {blkValid, blkMean}, 0);

    fillImage(0); sendFrame(0);     // saturated, R2
    fillImage(1); sendFrame(25);    // zero with gaps, R8
    fillImage(2); sendFrame(0);     // ramp at full rate, R7
    for (int f = 3; f < NFRAMES; f++) begin
      fillImage(3);
      sendFrame((f % 2) ? 0 : 30);  // back-to-back frames wrap the counter, R6 R9
    end
    @(negedge clk);
    pixValid = 1'b0;
    repeat (BC * 16 + 40) @(negedge clk);

    check(validCount == NFRAMES * BC * BR, "R5 tile count", validCount, NFRAMES * BC * BR);
    check(expQ.size() == 0, "R5 missing tiles", expQ.size(), 0);
    check(!blkValid, "R5 strobe idle at end", blkValid, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R5 watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule